// File: doc/BRIEF.md
# Keyboard Controller Host Mailbox

This block is the byte-wide mailbox between a host bus and an embedded core for a legacy keyboard/mouse channel. The host sees two ports, selected by one address line: the data port (legacy 60h) and the status/command port (legacy 64h). The core sees a strobe that reads the input buffer, two strobes that load the output buffer as keyboard or mouse data, and a strobe that updates the firmware-owned flag bits of the status byte.

The block holds one input buffer written by the host and one output buffer written by the core. It keeps a status byte that combines the hardware handshake bits (output full, input full, last-write-was-command) with five flags that only firmware writes. It raises a level interrupt to the core while the input buffer holds an unread byte and the interrupt enable is set. All strobes are single-cycle, in one clock domain. When a set event and a clear event hit the same status bit in the same cycle, the set wins.

Top module: `kbc_mailbox`

## Requirements
- R1: After synchronous reset the status byte is 00h, `core_irq` is 0, `host_rdata` is 00h, the input buffer reads 00h and `core_obuf_mouse` is 0.
- R2: A core keyboard or mouse write loads the output buffer and sets status bit 0 (OBF). A host read with `host_port`=0 returns the output-buffer byte on `host_rdata` in the next cycle and clears OBF.
- R3: A host write with `host_port`=0 loads the input buffer, sets status bit 1 (IBF) and clears status bit 3. A host write with `host_port`=1 loads the same buffer, sets IBF and sets status bit 3.
- R4: A core input-buffer read strobe clears IBF; `core_ibuf_data` always shows the input buffer and bit 3 is unchanged by the read.
- R5: A core flag write copies `core_wdata` bit 2 into status bit 2 and bits 7:4 into status bits 7:4; bits 0, 1 and 3 of that write are ignored, and host writes never change bits 2 and 7:4.
- R6: A host read with `host_port`=1 returns, in the next cycle, the status byte as it was before that cycle's updates, and does not clear OBF; `core_status` always shows the status byte.
- R7: `core_irq` is 1 in the cycle after a host write while `core_irq_en` is 1, stays 1 while IBF and the enable are both 1, and drops in the cycle after the core reads the input buffer or the enable falls.
- R8: A core write while OBF=1 replaces the output byte with OBF kept set; a host write while IBF=1 replaces the input byte and bit 3.
- R9: `core_obuf_mouse` is 1 after a mouse output write and 0 after a keyboard output write.
- R10: A set and a clear of OBF, or of IBF, in the same cycle leave the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_port | input | 1 | Host port select: 0 data, 1 status/command |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, registered |
| core_ibuf_rd | input | 1 | Core input-buffer read strobe |
| core_kbd_wr | input | 1 | Core keyboard output write strobe |
| core_mou_wr | input | 1 | Core mouse output write strobe |
| core_flag_wr | input | 1 | Core firmware-flag write strobe |
| core_wdata | input | 8 | Core write byte |
| core_irq_en | input | 1 | Input-full interrupt enable |
| core_ibuf_data | output | 8 | Input buffer contents |
| core_status | output | 8 | Status byte |
| core_obuf_mouse | output | 1 | Last output write came from the mouse strobe |
| core_irq | output | 1 | Input-full interrupt to the core |

## Verification
The bench targets same-cycle collisions of set and clear on OBF and IBF, where a design with clear priority would lose a byte the other side has just posted. It overwrites full buffers to catch a design that blocks or drops the second write, and reads the status port while OBF is set to catch a design that clears OBF on any host read. It also writes all-ones flag bytes to catch handshake bits leaking from the flag path, and toggles the interrupt enable while IBF is held to catch an interrupt that is edge-only or ignores the enable.

// File: rtl/kbc_pkg.sv
package kbc_pkg;
  localparam int STW      = 8;
  localparam int B_OBF    = 0;
  localparam int B_IBF    = 1;
  localparam int B_F0     = 2;
  localparam int B_CMD    = 3;
  localparam int B_USR_LO = 4;
  localparam int USR_W    = 4;
endpackage

// File: rtl/kbc_inbuf.sv
module kbc_inbuf #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_wr,
  input  logic          host_cmd,
  input  logic [DW-1:0] host_wdata,
  input  logic          core_rd,
  input  logic          irq_en,
  output logic [DW-1:0] ibuf,
  output logic          ibf,
  output logic          cmd_flag,
  output logic          irq
);
  logic ibf_n;

  always_comb begin
    ibf_n = ibf;
    if (core_rd) ibf_n = 1'b0;
    if (host_wr) ibf_n = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ibuf     <= '0;
      ibf      <= 1'b0;
      cmd_flag <= 1'b0;
      irq      <= 1'b0;
    end else begin
      ibf <= ibf_n;
      irq <= ibf_n & irq_en;
      if (host_wr) begin
        ibuf     <= host_wdata;
        cmd_flag <= host_cmd;
      end
    end
  end

  assert_ibf_set_R3: assert property (@(posedge clk) disable iff (rst)
    host_wr |=> ibf);
  assert_cmd_track_R8: assert property (@(posedge clk) disable iff (rst)
    host_wr |=> cmd_flag == $past(host_cmd));
  assert_ibf_clear_R4: assert property (@(posedge clk) disable iff (rst)
    (core_rd && !host_wr) |=> !ibf);
  assert_irq_needs_ibf_R7: assert property (@(posedge clk) disable iff (rst)
    irq |-> ibf);
  assert_irq_level_R7: assert property (@(posedge clk) disable iff (rst)
    (ibf && !core_rd && irq_en) |=> irq);
endmodule

// File: rtl/kbc_outbuf.sv
module kbc_outbuf #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          kbd_wr,
  input  logic          mou_wr,
  input  logic [DW-1:0] wdata,
  input  logic          host_take,
  output logic [DW-1:0] obuf,
  output logic          obf,
  output logic          src_mouse
);
  logic load;
  assign load = kbd_wr | mou_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      obuf      <= '0;
      obf       <= 1'b0;
      src_mouse <= 1'b0;
    end else begin
      if (load) begin
        obuf      <= wdata;
        obf       <= 1'b1;
        src_mouse <= mou_wr;
      end else if (host_take) begin
        obf <= 1'b0;
      end
    end
  end

  assert_obf_set_R10: assert property (@(posedge clk) disable iff (rst)
    load |=> obf);
  assert_obf_clear_R2: assert property (@(posedge clk) disable iff (rst)
    (host_take && !load) |=> !obf);
  assert_obuf_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(obuf));
endmodule

// File: rtl/kbc_flags.sv
module kbc_flags
  import kbc_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [DW-1:0]    wdata,
  output logic             f0,
  output logic [USR_W-1:0] usr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      f0  <= 1'b0;
      usr <= '0;
    end else if (wr) begin
      f0  <= wdata[B_F0];
      usr <= wdata[B_USR_LO +: USR_W];
    end
  end

  assert_flags_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !wr |=> ($stable(f0) && $stable(usr)));
endmodule

// File: rtl/kbc_mailbox.sv
module kbc_mailbox
  import kbc_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_port,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  input  logic          core_ibuf_rd,
  input  logic          core_kbd_wr,
  input  logic          core_mou_wr,
  input  logic          core_flag_wr,
  input  logic [DW-1:0] core_wdata,
  input  logic          core_irq_en,
  output logic [DW-1:0] core_ibuf_data,
  output logic [STW-1:0] core_status,
  output logic          core_obuf_mouse,
  output logic          core_irq
);
  logic [DW-1:0]    obuf;
  logic             obf, ibf, cmd_flag, f0;
  logic [USR_W-1:0] usr;
  logic             host_take;

  assign host_take = host_rd & ~host_port;

  kbc_inbuf #(.DW(DW)) u_in (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_cmd(host_port),
    .host_wdata(host_wdata), .core_rd(core_ibuf_rd), .irq_en(core_irq_en),
    .ibuf(core_ibuf_data), .ibf(ibf), .cmd_flag(cmd_flag), .irq(core_irq)
  );

  kbc_outbuf #(.DW(DW)) u_out (
    .clk(clk), .rst(rst), .kbd_wr(core_kbd_wr), .mou_wr(core_mou_wr),
    .wdata(core_wdata), .host_take(host_take), .obuf(obuf), .obf(obf),
    .src_mouse(core_obuf_mouse)
  );

  kbc_flags #(.DW(DW)) u_flags (
    .clk(clk), .rst(rst), .wr(core_flag_wr), .wdata(core_wdata),
    .f0(f0), .usr(usr)
  );

  always_comb begin
    core_status              = '0;
    core_status[B_OBF]       = obf;
    core_status[B_IBF]       = ibf;
    core_status[B_F0]        = f0;
    core_status[B_CMD]       = cmd_flag;
    core_status[B_USR_LO +: USR_W] = usr;
  end

  always_ff @(posedge clk) begin
    if (rst) host_rdata <= '0;
    else if (host_rd) host_rdata <= host_port ? core_status : obuf;
  end

  assert_rdata_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !host_rd |=> $stable(host_rdata));
  assert_host_no_flag_R5: assert property (@(posedge clk) disable iff (rst)
    !core_flag_wr |=> $stable(core_status[7:4]));
endmodule

// File: tb/kbc_mailbox_tb.sv
module kbc_mailbox_tb;
  typedef struct packed {
    logic [3:0] req;
    logic       hwr, hrd, hport;
    logic [7:0] hd;
    logic       crd, ckbd, cmou, cfl;
    logic [7:0] cd;
    logic       en;
    logic [7:0] st;
    logic       irq;
    logic [7:0] rd;
    logic [7:0] ib;
    logic       mou;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{4'd3,  1'b1,1'b0,1'b0,8'h11, 1'b0,1'b0,1'b0,1'b0,8'h00, 1'b1, 8'h02,1'b1,8'h00,8'h11,1'b0},
    '{4'd8,  1'b1,1'b0,1'b1,8'hAA, 1'b0,1'b0,1'b0,1'b0,8'h00, 1'b1, 8'h0A,1'b1,8'h00,8'hAA,1'b0},
    '{4'd4,  1'b0,1'b0,1'b0,8'h00, 1'b1,1'b0,1'b0,1'b0,8'h00, 1'b1, 8'h08,1'b0,8'h00,8'hAA,1'b0},
    '{4'd2,  1'b0,1'b0,1'b0,8'h00, 1'b0,1'b1,1'b0,1'b0,8'h5C, 1'b1, 8'h09,1'b0,8'h00,8'hAA,1'b0},
    '{4'd6,  1'b0,1'b1,1'b1,8'h00, 1'b0,1'b0,1'b0,1'b0,8'h00, 1'b1, 8'h09,1'b0,8'h09,8'hAA,1'b0},
    '{4'd9,  1'b0,1'b0,1'b0,8'h00, 1'b0,1'b0,1'b1,1'b0,8'h77, 1'b1, 8'h09,1'b0,8'h09,8'hAA,1'b1},
    '{4'd2,  1'b0,1'b1,1'b0,8'h00, 1'b0,1'b0,1'b0,1'b0,8'h00, 1'b1, 8'h08,1'b0,8'h77,8'hAA,1'b1},
    '{4'd5,  1'b0,1'b0,1'b0,8'h00, 1'b0,1'b0,1'b0,1'b1,8'hFF, 1'b1, 8'hFC,1'b0,8'h77,8'hAA,1'b1},
    '{4'd7,  1'b1,1'b0,1'b0,8'h33, 1'b0,1'b0,1'b0,1'b0,8'h00, 1'b0, 8'hF6,1'b0,8'h77,8'h33,1'b1},
    '{4'd7,  1'b0,1'b0,1'b0,8'h00, 1'b0,1'b0,1'b0,1'b0,8'h00, 1'b1, 8'hF6,1'b1,8'h77,8'h33,1'b1},
    '{4'd10, 1'b1,1'b0,1'b1,8'h44, 1'b1,1'b0,1'b0,1'b0,8'h00, 1'b1, 8'hFE,1'b1,8'h77,8'h44,1'b1},
    '{4'd10, 1'b0,1'b1,1'b0,8'h00, 1'b0,1'b1,1'b0,1'b0,8'h21, 1'b1, 8'hFF,1'b1,8'h77,8'h44,1'b0},
    '{4'd5,  1'b0,1'b0,1'b0,8'h00, 1'b0,1'b0,1'b0,1'b1,8'h00, 1'b1, 8'h0B,1'b1,8'h77,8'h44,1'b0},
    '{4'd7,  1'b0,1'b0,1'b0,8'h00, 1'b1,1'b0,1'b0,1'b0,8'h00, 1'b1, 8'h09,1'b0,8'h77,8'h44,1'b0},
    '{4'd2,  1'b0,1'b1,1'b0,8'h00, 1'b0,1'b0,1'b0,1'b0,8'h00, 1'b1, 8'h08,1'b0,8'h21,8'h44,1'b0}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       host_port = 1'b0, host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0] host_wdata = '0, host_rdata;
  logic       core_ibuf_rd = 1'b0, core_kbd_wr = 1'b0, core_mou_wr = 1'b0;
  logic       core_flag_wr = 1'b0, core_irq_en = 1'b0;
  logic [7:0] core_wdata = '0, core_ibuf_data, core_status;
  logic       core_obuf_mouse, core_irq;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  kbc_mailbox u_dut (
    .clk(clk), .rst(rst), .host_port(host_port), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .core_ibuf_rd(core_ibuf_rd), .core_kbd_wr(core_kbd_wr),
    .core_mou_wr(core_mou_wr), .core_flag_wr(core_flag_wr),
    .core_wdata(core_wdata), .core_irq_en(core_irq_en),
    .core_ibuf_data(core_ibuf_data), .core_status(core_status),
    .core_obuf_mouse(core_obuf_mouse), .core_irq(core_irq)
  );

  function automatic string rname(input logic [3:0] r);
    case (r)
      4'd1: return "R1";   4'd2: return "R2";   4'd3: return "R3";
      4'd4: return "R4";   4'd5: return "R5";   4'd6: return "R6";
      4'd7: return "R7";   4'd8: return "R8";   4'd9: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic check_reset_state();
    chk("R1", "status", core_status, 8'h00);
    chk("R1", "irq", {7'd0, core_irq}, 8'h00);
    chk("R1", "host_rdata", host_rdata, 8'h00);
    chk("R1", "ibuf", core_ibuf_data, 8'h00);
    chk("R1", "mouse", {7'd0, core_obuf_mouse}, 8'h00);
  endtask

  initial begin
    #2000000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    #1 check_reset_state();
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      host_wr = VEC[i].hwr; host_rd = VEC[i].hrd; host_port = VEC[i].hport;
      host_wdata = VEC[i].hd; core_ibuf_rd = VEC[i].crd;
      core_kbd_wr = VEC[i].ckbd; core_mou_wr = VEC[i].cmou;
      core_flag_wr = VEC[i].cfl; core_wdata = VEC[i].cd;
      core_irq_en = VEC[i].en;
      @(posedge clk); #1;
      chk(rname(VEC[i].req), "status", core_status, VEC[i].st);
      chk(rname(VEC[i].req), "irq", {7'd0, core_irq}, {7'd0, VEC[i].irq});
      chk(rname(VEC[i].req), "host_rdata", host_rdata, VEC[i].rd);
      chk(rname(VEC[i].req), "ibuf", core_ibuf_data, VEC[i].ib);
      chk(rname(VEC[i].req), "mouse", {7'd0, core_obuf_mouse}, {7'd0, VEC[i].mou});
    end
    // R7: enable falls while IBF held -> irq drops next cycle
    @(negedge clk);
    host_wr = 1'b1; host_port = 1'b0; host_wdata = 8'h5A; host_rd = 1'b0;
    core_ibuf_rd = 1'b0; core_kbd_wr = 1'b0; core_mou_wr = 1'b0; core_flag_wr = 1'b0;
    core_irq_en = 1'b1;
    @(posedge clk); #1;
    chk("R7", "irq after write", {7'd0, core_irq}, 8'h01);
    @(negedge clk) begin host_wr = 1'b0; core_irq_en = 1'b0; end
    @(posedge clk); #1;
    chk("R7", "irq after enable low", {7'd0, core_irq}, 8'h00);
    chk("R4", "ibf kept", core_status & 8'h02, 8'h02);
    // R1: reset mid-operation
    @(negedge clk) rst = 1'b1;
    @(posedge clk); #1;
    check_reset_state();
    @(negedge clk) rst = 1'b0;
    @(posedge clk); #1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule